// File: doc/BRIEF.md
# Queue-Occupancy Frequency Level Controller

This block chooses the voltage-frequency operating point of a redundant trailing core. The trailing core buffers incoming branch targets and forwarded instruction results in two queues. When either queue fills up, the core is falling behind and must run faster. When either queue drains, the core has slack and can run slower to save energy.

A programmable interval timer defines the decision instants. At each of them the block compares both queue occupancies with a programmable low and high threshold for that queue. It then moves a level index one step up, one step down, or leaves it where it is. The index addresses a fixed table of operating points, and the table entry is presented as a frequency code and a voltage code for the regulator and clock generator. The interval can be set from one cycle up to about a million cycles, which covers both microsecond and millisecond update rates.

Top module: `qlc_freq_level_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the level becomes the top table entry (LVL_N-1, highest frequency) and stays there until the first decision.
- R2: With an interval setting N of 2 or more, decisions happen only at the N-th rising edge after reset release and every N edges thereafter. The level holds between decisions, so each decision is applied for exactly one interval.
- R3: At a decision, the level rises by one if the branch occupancy is strictly above its high threshold or the result occupancy is strictly above its high threshold.
- R4: At a decision with no raise condition, the level falls by one if either occupancy is strictly below its own low threshold.
- R5: When a raise condition and a lower condition hold at the same decision, the level rises.
- R6: At a decision where every occupancy lies within its thresholds, the level is unchanged. An occupancy equal to a threshold counts as within it.
- R7: The level saturates: a raise at LVL_N-1 and a lower at 0 leave it unchanged.
- R8: The outputs give the table entry of the current level: `freq_code` = F_MIN + level*F_STEP and `volt_code` = V_MIN + level*V_STEP. The defaults are 500 and 250 for frequency, and 600 and 50 for voltage.
- R9: An interval setting of 0 or 1 makes a decision at every rising edge.
- R10: If the interval setting is lowered while the elapsed count already equals or exceeds the new N-1, the decision happens at the next rising edge and a new interval starts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval_cycles | input | INTV_W | Decision interval N in clock cycles (0 and 1 mean every cycle) |
| br_occ | input | OCC_W | Current branch-target queue occupancy |
| br_lo_thr | input | OCC_W | Branch queue low threshold |
| br_hi_thr | input | OCC_W | Branch queue high threshold |
| res_occ | input | OCC_W | Current result queue occupancy |
| res_lo_thr | input | OCC_W | Result queue low threshold |
| res_hi_thr | input | OCC_W | Result queue high threshold |
| level | output | LVL_W | Current operating-point index, 0 is slowest |
| freq_code | output | FREQ_W | Frequency of the current entry in MHz |
| volt_code | output | VOLT_W | Voltage of the current entry in mV |

## Verification
The properties assume that occupancies and thresholds are stable around the sampling edge, and that each low threshold is set no higher than its high threshold. The bench drives every input at the falling edge and keeps every threshold pair ordered.

The properties also assume that the interval changes only rarely, so that a decision always closes a full interval. For this reason the bench reprograms the interval in only a few places. The R10 case is among them: it shortens the interval mid-count on purpose, and the model checks that case while the properties only require stability away from decision edges.

// File: rtl/qlc_pkg.sv
// Shared types for the queue-occupancy level controller.
// Assumes nothing beyond the 2017 language standard.
package qlc_pkg;

    // Outcome of one decision instant
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

    // Number of monitored queues: branch targets and results
    localparam int NQ = 2;

endpackage

// File: rtl/qlc_interval_timer.sv
// Interval timer: asserts tick on the last cycle of each decision interval.
// Assumes interval_cycles may change at any time; a value below 2 means
// a decision on every cycle, and a count already past the new limit ends
// the interval at once.
module qlc_interval_timer #(
    parameter int INTV_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] interval_cycles,
    output logic              tick
);

    logic [INTV_W-1:0] cnt_q;
    logic [INTV_W-1:0] last_cnt;

    // Index of the final cycle in the current interval
    always_comb begin
        if (interval_cycles <= INTV_W'(1)) begin
            last_cnt = '0;
        end else begin
            last_cnt = interval_cycles - INTV_W'(1);
        end
    end

    // Interval ends when the count reaches or passes the final index
    assign tick = (cnt_q >= last_cnt);

    // Cycle counter, cleared at each interval end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + INTV_W'(1);
        end
    end

endmodule

// File: rtl/qlc_queue_cmp.sv
// Threshold comparator for one queue: flags occupancy strictly above the
// high threshold or strictly below the low threshold.
// Assumes lo_thr <= hi_thr; if not, both flags may be set and the
// decider resolves them in favour of raising.
module qlc_queue_cmp #(
    parameter int OCC_W = 8
) (
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lo_thr,
    input  logic [OCC_W-1:0] hi_thr,
    output logic             over,
    output logic             under
);

    // Strict comparisons: equality counts as in range
    always_comb begin
        over  = (occ > hi_thr);
        under = (occ < lo_thr);
    end

endmodule

// File: rtl/qlc_step_decider.sv
// Combines per-queue flags into one step: any over-threshold queue
// asks for a raise, which wins over any under-threshold queue.
// Assumes flags are valid in the cycle they are used.
module qlc_step_decider
    import qlc_pkg::*;
#(
    parameter int NUM_Q = 2
) (
    input  logic [NUM_Q-1:0] over,
    input  logic [NUM_Q-1:0] under,
    output step_e            step
);

    // Priority: raise, then lower, then hold
    always_comb begin
        if (|over) begin
            step = STEP_UP;
        end else if (|under) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_HOLD;
        end
    end

endmodule

// File: rtl/qlc_level_reg.sv
// Saturating level register: applies the step only on a tick and stays
// within 0 .. LVL_N-1. Resets to the top entry.
// Assumes step is meaningful only when tick is high.
module qlc_level_reg
    import qlc_pkg::*;
#(
    parameter int LVL_N = 8,
    localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  step_e            step,
    output logic [LVL_W-1:0] level
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LVL_N - 1);

    logic [LVL_W-1:0] level_q;

    // Level update at decision instants with saturation at both ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_MAX;
        end else if (tick) begin
            case (step)
                STEP_UP: begin
                    if (level_q != LVL_MAX) begin
                        level_q <= level_q + LVL_W'(1);
                    end
                end
                STEP_DOWN: begin
                    if (level_q != '0) begin
                        level_q <= level_q - LVL_W'(1);
                    end
                end
                default: begin
                    level_q <= level_q;
                end
            endcase
        end
    end

    assign level = level_q;

endmodule

// File: rtl/qlc_vf_lookup.sv
// Operating-point table: a linear map from level index to frequency and
// voltage codes, computed rather than stored.
// Assumes the parameters keep the top entry within the code widths.
module qlc_vf_lookup #(
    parameter int LVL_N      = 8,
    parameter int FREQ_W     = 12,
    parameter int VOLT_W     = 11,
    parameter int F_MIN_MHZ  = 500,
    parameter int F_STEP_MHZ = 250,
    parameter int V_MIN_MV   = 600,
    parameter int V_STEP_MV  = 50,
    localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
    input  logic [LVL_W-1:0]  level,
    output logic [FREQ_W-1:0] freq_code,
    output logic [VOLT_W-1:0] volt_code
);

    // Table entry for the current index
    always_comb begin
        freq_code = FREQ_W'(F_MIN_MHZ + int'(level) * F_STEP_MHZ);
        volt_code = VOLT_W'(V_MIN_MV + int'(level) * V_STEP_MV);
    end

endmodule

// File: rtl/qlc_freq_level_ctrl.sv
// Top level: periodic frequency-level selection from two queue occupancies.
// Assumes synchronous inputs; thresholds and interval are quasi-static
// configuration driven by the surrounding logic.
module qlc_freq_level_ctrl
    import qlc_pkg::*;
#(
    parameter int OCC_W      = 8,
    parameter int INTV_W     = 20,
    parameter int LVL_N      = 8,
    parameter int FREQ_W     = 12,
    parameter int VOLT_W     = 11,
    parameter int F_MIN_MHZ  = 500,
    parameter int F_STEP_MHZ = 250,
    parameter int V_MIN_MV   = 600,
    parameter int V_STEP_MV  = 50,
    localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] interval_cycles,
    input  logic [OCC_W-1:0]  br_occ,
    input  logic [OCC_W-1:0]  br_lo_thr,
    input  logic [OCC_W-1:0]  br_hi_thr,
    input  logic [OCC_W-1:0]  res_occ,
    input  logic [OCC_W-1:0]  res_lo_thr,
    input  logic [OCC_W-1:0]  res_hi_thr,
    output logic [LVL_W-1:0]  level,
    output logic [FREQ_W-1:0] freq_code,
    output logic [VOLT_W-1:0] volt_code
);

    logic [OCC_W-1:0] occ_arr [NQ];
    logic [OCC_W-1:0] lo_arr  [NQ];
    logic [OCC_W-1:0] hi_arr  [NQ];
    logic [NQ-1:0]    over_vec;
    logic [NQ-1:0]    under_vec;
    logic             upd_tick;
    step_e            step;

    // Gather per-queue inputs into arrays, index 0 branch, 1 result
    always_comb begin
        occ_arr[0] = br_occ;
        lo_arr[0]  = br_lo_thr;
        hi_arr[0]  = br_hi_thr;
        occ_arr[1] = res_occ;
        lo_arr[1]  = res_lo_thr;
        hi_arr[1]  = res_hi_thr;
    end

    qlc_interval_timer #(
        .INTV_W (INTV_W)
    ) u_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .interval_cycles (interval_cycles),
        .tick            (upd_tick)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_cmp
        qlc_queue_cmp #(
            .OCC_W (OCC_W)
        ) u_cmp (
            .occ    (occ_arr[q]),
            .lo_thr (lo_arr[q]),
            .hi_thr (hi_arr[q]),
            .over   (over_vec[q]),
            .under  (under_vec[q])
        );
    end

    qlc_step_decider #(
        .NUM_Q (NQ)
    ) u_decide (
        .over  (over_vec),
        .under (under_vec),
        .step  (step)
    );

    qlc_level_reg #(
        .LVL_N (LVL_N)
    ) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (upd_tick),
        .step  (step),
        .level (level)
    );

    qlc_vf_lookup #(
        .LVL_N      (LVL_N),
        .FREQ_W     (FREQ_W),
        .VOLT_W     (VOLT_W),
        .F_MIN_MHZ  (F_MIN_MHZ),
        .F_STEP_MHZ (F_STEP_MHZ),
        .V_MIN_MV   (V_MIN_MV),
        .V_STEP_MV  (V_STEP_MV)
    ) u_lookup (
        .level     (level),
        .freq_code (freq_code),
        .volt_code (volt_code)
    );

endmodule

// File: rtl/qlc_level_ctrl_chk.sv
// Property checker for the level controller, attached by bind.
// Assumes tick is the timer's decision strobe inside the top module.
module qlc_level_ctrl_chk #(
    parameter int OCC_W = 8,
    parameter int LVL_N = 8,
    localparam int LVL_W = (LVL_N > 1) ? $clog2(LVL_N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [OCC_W-1:0] br_occ,
    input logic [OCC_W-1:0] br_lo_thr,
    input logic [OCC_W-1:0] br_hi_thr,
    input logic [OCC_W-1:0] res_occ,
    input logic [OCC_W-1:0] res_lo_thr,
    input logic [OCC_W-1:0] res_hi_thr,
    input logic [LVL_W-1:0] level
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LVL_N - 1);

    logic want_up;
    logic want_down;

    // Requested direction seen at the ports
    always_comb begin
        want_up   = (br_occ > br_hi_thr) || (res_occ > res_hi_thr);
        want_down = (br_occ < br_lo_thr) || (res_occ < res_lo_thr);
    end

    assert_reset_top_R1: assert property (@(posedge clk)
        !rst_n |=> level == LVL_MAX);

    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level));

    assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && want_up && level != LVL_MAX) |=> level == $past(level) + LVL_W'(1));

    assert_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !want_up && want_down && level != '0) |=> level == $past(level) - LVL_W'(1));

    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !want_up && !want_down) |=> $stable(level));

    assert_saturate_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && want_up && level == LVL_MAX) |=> level == LVL_MAX);

    assert_saturate_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !want_up && want_down && level == '0) |=> level == '0);

endmodule

bind qlc_freq_level_ctrl qlc_level_ctrl_chk #(
    .OCC_W (OCC_W),
    .LVL_N (LVL_N)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (upd_tick),
    .br_occ     (br_occ),
    .br_lo_thr  (br_lo_thr),
    .br_hi_thr  (br_hi_thr),
    .res_occ    (res_occ),
    .res_lo_thr (res_lo_thr),
    .res_hi_thr (res_hi_thr),
    .level      (level)
);

// File: tb/sim_qlc_freq_level_ctrl.sv
// Bench: behavioural reference model compared on every clock.
module sim_qlc_freq_level_ctrl;

    localparam int OCC_W  = 8;
    localparam int INTV_W = 20;
    localparam int LVL_N  = 8;
    localparam int LVL_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [INTV_W-1:0] interval_cycles = 20'd4;
    logic [OCC_W-1:0]  br_occ = 8'd10;
    logic [OCC_W-1:0]  br_lo_thr = 8'd4;
    logic [OCC_W-1:0]  br_hi_thr = 8'd20;
    logic [OCC_W-1:0]  res_occ = 8'd20;
    logic [OCC_W-1:0]  res_lo_thr = 8'd8;
    logic [OCC_W-1:0]  res_hi_thr = 8'd40;
    logic [LVL_W-1:0]  level;
    logic [11:0]       freq_code;
    logic [10:0]       volt_code;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    int m_lvl = LVL_N - 1;
    string m_tag = "R1";
    bit started = 1'b0;

    always #5 clk = ~clk;

    qlc_freq_level_ctrl u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .interval_cycles (interval_cycles),
        .br_occ          (br_occ),
        .br_lo_thr       (br_lo_thr),
        .br_hi_thr       (br_hi_thr),
        .res_occ         (res_occ),
        .res_lo_thr      (res_lo_thr),
        .res_hi_thr      (res_hi_thr),
        .level           (level),
        .freq_code       (freq_code),
        .volt_code       (volt_code)
    );

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        int n;
        bit up;
        bit dn;
        started = 1'b1;
        if (!rst_n) begin
            m_cnt = 0;
            m_lvl = LVL_N - 1;
            m_tag = "R1";
        end else begin
            n = (interval_cycles < 2) ? 1 : int'(interval_cycles);
            if (m_cnt >= n - 1) begin
                up = (br_occ > br_hi_thr) || (res_occ > res_hi_thr);
                dn = (br_occ < br_lo_thr) || (res_occ < res_lo_thr);
                if (up) begin
                    if (m_lvl < LVL_N - 1) begin
                        m_lvl++;
                        m_tag = dn ? "R5" : "R3";
                    end else m_tag = "R7";
                end else if (dn) begin
                    if (m_lvl > 0) begin
                        m_lvl--;
                        m_tag = "R4";
                    end else m_tag = "R7";
                end else m_tag = "R6";
                if (m_cnt > n - 1) m_tag = {m_tag, "/R10"};
                if (n == 1) m_tag = {m_tag, "/R9"};
                m_cnt = 0;
            end else begin
                m_cnt++;
                m_tag = "R2";
            end
        end
    end

    // Comparison at the falling edge
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (int'(level) != m_lvl) begin
                n_fail++;
                $display("FAIL %s: level actual %0d expected %0d", m_tag, level, m_lvl);
            end
            n_chk++;
            if (int'(freq_code) != 500 + m_lvl * 250 || int'(volt_code) != 600 + m_lvl * 50) begin
                n_fail++;
                $display("FAIL R8: freq/volt actual %0d/%0d expected %0d/%0d",
                         freq_code, volt_code, 500 + m_lvl * 250, 600 + m_lvl * 50);
            end
        end
    end

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic set_occ(input int b, input int r);
        br_occ  = OCC_W'(b);
        res_occ = OCC_W'(r);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Stimulus
    initial begin
        run(3);                        // R1 reset holds top entry
        rst_n = 1'b1;
        set_occ(10, 20); run(16);      // R6 within range, R2 spacing
        set_occ(4, 40);  run(12);      // R6 equal to thresholds
        set_occ(2, 20);  run(40);      // R4 lowering, R7 bottom
        set_occ(25, 20); run(12);      // R3 branch high
        set_occ(10, 50); run(12);      // R3 result high
        set_occ(30, 2);  run(12);      // R5 raise wins
        set_occ(30, 20); run(32);      // R7 top saturation
        set_occ(10, 3);  run(12);      // R4 result low
        interval_cycles = 20'd1;
        set_occ(2, 20);  run(5);       // R9 every cycle
        interval_cycles = 20'd0;
        set_occ(30, 20); run(5);       // R9 zero setting
        interval_cycles = 20'd50;
        set_occ(10, 20); run(20);
        interval_cycles = 20'd5;       // R10 count already past limit
        set_occ(2, 20);  run(30);
        interval_cycles = 20'd1000;
        run(3500);                     // long interval
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule